// File: doc/BRIEF.md
# Trigger-Tower Link Frame Packer and Checker

This block sends the energies of 32 trigger towers for each bunch crossing over a board-to-board parallel link. It sends them one bit plane at a time. Each link word carries the same bit position of all 32 tower values. The 32 data bits of a word are spread over six 7-bit lane groups that feed the serializers. The spare lane slots carry a framing bit, a payload-mode bit and an even-parity bit. In the filtered mode a crossing takes 8 words, with 8-bit values. In the raw mode it takes 10 words, with 10-bit values.

The transmit side runs freely after reset. It captures a new set of tower values and a new mode on the clock edge that ends the previous crossing. The receive side is in the same block. It rebuilds the 32-bit word from the lane groups and raises one-cycle flags for parity faults and for framing bits that arrive early or not at all. In normal use the transmit lanes are cabled or looped to the receive lanes of a partner.

Top module: `tt_link_framer`

## Requirements
- R1: While reset is held, `tx_lanes`, `rx_word`, `rx_par_err` and `rx_sync_err` are all zero. Before the first crossing starts, `tx_lanes` stays zero.
- R2: The framing bit is 1 on the first word of every crossing and 0 on every other word. A crossing lasts 8 words when its mode bit is 0 (filtered) and 10 words when it is 1 (raw).
- R3: Tower t occupies `tx_pay[10t+9:10t]`. Word k of a crossing (k counted from 0) carries bit k of tower t as data bit t.
- R4: In filtered mode, bits 8 and 9 of every tower value have no effect on any word.
- R5: Lane j occupies `tx_lanes[7j+6:7j]`. The lane contents are:
  - lane 0: data bits 5..0 in positions 5..0, and the framing bit in position 6.
  - lane 1: data bits 13..8 in positions 5..0, and the mode bit (1 = raw) in position 6.
  - lane 2: data bits 21..16 in positions 5..0, and the parity bit in position 6.
  - lane 3: data bits 23,22,15,14,7,6 in positions 5..0, and 0 in position 6.
  - lane 4: data bits 29..24 in positions 5..0, and 0 in position 6.
  - lane 5: data bits 31,30 in positions 1..0, and 0 elsewhere.
- R6: The parity bit makes the count of ones across the 32 data bits plus the parity bit even.
- R7: Tower values and mode are captured only on the edge that ends the previous crossing. Changes during a crossing do not alter that crossing.
- R8: `rx_word` shows, one clock after a word is present on `rx_lanes`, that word's 32 data bits decoded with the R5 routing.
- R9: `rx_par_err` is 1 for one cycle, one clock after a word whose data and parity bits hold an odd count of ones.
- R10: The receiver locks on the first framing bit it sees. While locked, `rx_sync_err` pulses one clock after either of two faults: a framing bit before the last word of the crossing (the length comes from the mode bit seen with the last framing bit), or a missing framing bit on the word that follows that last word. A change of mode between crossings is not a fault.
- R11: After a missing framing bit, the receiver drops lock and reports no sync fault until the next framing bit. That framing bit re-locks it without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_pay | input | 320 | 32 tower values of 10 bits, tower t at bits 10t+9..10t |
| tx_mon | input | 1 | Payload mode for the next crossing: 0 filtered 8-bit, 1 raw 10-bit |
| tx_lanes | output | 42 | Six 7-bit transmit lane groups |
| rx_lanes | input | 42 | Six 7-bit receive lane groups |
| rx_word | output | 32 | Decoded data bits of the last received word |
| rx_par_err | output | 1 | Parity fault pulse |
| rx_sync_err | output | 1 | Framing fault pulse |

## Verification
A looped-back transmitter never produces a framing fault, so the sync and re-lock paths cannot be reached from clean stimulus. The bench places an XOR mask between `tx_lanes` and `rx_lanes` for exactly one word. Each fault is placed at a known word position: a framing bit set in the middle of a crossing, or the framing bit removed from a crossing's first word. The expected fault pulses and the quiet, unlocked stretch that follows are then predicted cycle by cycle. Capture timing is exercised by driving junk tower values and a flipped mode during every crossing, and restoring the intended ones before the capture edge.

// File: rtl/lkp_pkg.sv
package lkp_pkg;
  localparam int DW      = 32;
  localparam int NLANE   = 6;
  localparam int LW      = 7;
  localparam int LANES_W = NLANE * LW;
  localparam int CTRL_POS = 6;
  localparam int FR_IDX  = 0 * LW + CTRL_POS;
  localparam int MD_IDX  = 1 * LW + CTRL_POS;
  localparam int PB_IDX  = 2 * LW + CTRL_POS;

  // Lane that carries data bit i.
  function automatic int bit_lane(input int i);
    int g;
    int r;
    g = i / 8;
    r = i % 8;
    if (r < 6) return (g == 3) ? 4 : g;
    return (g == 3) ? 5 : 3;
  endfunction

  // Position inside its lane of data bit i.
  function automatic int bit_pos(input int i);
    int g;
    int r;
    g = i / 8;
    r = i % 8;
    if (r < 6) return r;
    return (g == 3) ? (r - 6) : (g * 2 + (r - 6));
  endfunction
endpackage

// File: rtl/lkp_tx_pack.sv
module lkp_tx_pack #(
  parameter int NTT   = 32,
  parameter int VAL_W = 10,
  parameter int NRM_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NTT-1:0][VAL_W-1:0]  val_i,
  input  logic                       mon_i,
  output logic [NTT-1:0]             word_o,
  output logic                       frame_o,
  output logic                       mode_o,
  output logic                       par_o
);
  localparam int CNT_W = $clog2(VAL_W);
  localparam logic [CNT_W-1:0] MON_LAST = CNT_W'(VAL_W - 1);
  localparam logic [CNT_W-1:0] NRM_LAST = CNT_W'(NRM_W - 1);

  logic                      started_q;
  logic [CNT_W-1:0]          cnt_q, cnt_d;
  logic [NTT-1:0][VAL_W-1:0] sh_q;
  logic                      mon_q;
  logic [CNT_W-1:0]          last_cnt;
  logic                      wrap;

  always_comb begin
    last_cnt = mon_q ? MON_LAST : NRM_LAST;
    wrap     = !started_q || (cnt_q == last_cnt);
    cnt_d    = wrap ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      mon_q     <= 1'b0;
    end else begin
      started_q <= 1'b1;
      cnt_q     <= cnt_d;
      if (wrap) begin
        sh_q  <= val_i;
        mon_q <= mon_i;
      end
    end
  end

  for (genvar t = 0; t < NTT; t++) begin : g_plane
    assign word_o[t] = started_q & sh_q[t][cnt_q];
  end

  assign frame_o = started_q && (cnt_q == '0);
  assign mode_o  = started_q & mon_q;
  assign par_o   = ^word_o;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (cnt_q <= last_cnt));
  p_frame_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |=> !frame_o);
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && cnt_q != '0) |-> $stable(mon_q));
endmodule

// File: rtl/lkp_lane_map.sv
module lkp_lane_map
  import lkp_pkg::*;
(
  input  logic [DW-1:0]      data_i,
  input  logic               fr_i,
  input  logic               md_i,
  input  logic               pb_i,
  output logic [LANES_W-1:0] lanes_o
);
  always_comb begin
    lanes_o = '0;
    for (int i = 0; i < DW; i++) begin
      lanes_o[bit_lane(i) * LW + bit_pos(i)] = data_i[i];
    end
    lanes_o[FR_IDX] = fr_i;
    lanes_o[MD_IDX] = md_i;
    lanes_o[PB_IDX] = pb_i;
  end
endmodule

// File: rtl/lkp_rx_check.sv
module lkp_rx_check
  import lkp_pkg::*;
#(
  parameter int VAL_W = 10,
  parameter int NRM_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES_W-1:0] lanes_i,
  output logic [DW-1:0]      word_o,
  output logic               par_err_o,
  output logic               sync_err_o
);
  localparam int CNT_W = $clog2(VAL_W);
  localparam logic [CNT_W-1:0] MON_LAST = CNT_W'(VAL_W - 1);
  localparam logic [CNT_W-1:0] NRM_LAST = CNT_W'(NRM_W - 1);

  logic [DW-1:0]    dat;
  logic             fr, md, pb;
  logic             locked_q, locked_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mon_q, mon_d;
  logic             serr_d, perr_d;
  logic [CNT_W-1:0] last_cnt;
  logic             at_end;

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      dat[i] = lanes_i[bit_lane(i) * LW + bit_pos(i)];
    end
    fr = lanes_i[FR_IDX];
    md = lanes_i[MD_IDX];
    pb = lanes_i[PB_IDX];
  end

  always_comb begin
    last_cnt = mon_q ? MON_LAST : NRM_LAST;
    at_end   = (cnt_q == last_cnt);
    locked_d = locked_q;
    cnt_d    = cnt_q;
    mon_d    = mon_q;
    serr_d   = 1'b0;
    if (fr) begin
      serr_d   = locked_q && !at_end;
      locked_d = 1'b1;
      cnt_d    = '0;
      mon_d    = md;
    end else if (locked_q) begin
      if (at_end) begin
        serr_d   = 1'b1;
        locked_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
    perr_d = ^{dat, pb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q   <= 1'b0;
      cnt_q      <= '0;
      mon_q      <= 1'b0;
      word_o     <= '0;
      par_err_o  <= 1'b0;
      sync_err_o <= 1'b0;
    end else begin
      locked_q   <= locked_d;
      cnt_q      <= cnt_d;
      mon_q      <= mon_d;
      word_o     <= dat;
      par_err_o  <= perr_d;
      sync_err_o <= serr_d;
    end
  end

  p_sync_needs_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_o |-> $past(locked_q));
  p_rx_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> (cnt_q <= last_cnt));
  p_unlock_on_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err_o && !$past(fr)) |-> !locked_q);
endmodule

// File: rtl/tt_link_framer.sv
module tt_link_framer
  import lkp_pkg::*;
#(
  parameter int VAL_W = 10,
  parameter int NRM_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW*VAL_W-1:0]   tx_pay,
  input  logic                  tx_mon,
  output logic [LANES_W-1:0]    tx_lanes,
  input  logic [LANES_W-1:0]    rx_lanes,
  output logic [DW-1:0]         rx_word,
  output logic                  rx_par_err,
  output logic                  rx_sync_err
);
  logic [1:0]                rs_q;
  logic                      rst_n_i;
  logic [DW-1:0][VAL_W-1:0]  vals;
  logic [DW-1:0]             tx_word;
  logic                      tx_fr, tx_md, tx_pb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  assign vals = tx_pay;

  lkp_tx_pack #(.NTT(DW), .VAL_W(VAL_W), .NRM_W(NRM_W)) u_tx (
    .clk(clk), .rst_n(rst_n_i), .val_i(vals), .mon_i(tx_mon),
    .word_o(tx_word), .frame_o(tx_fr), .mode_o(tx_md), .par_o(tx_pb)
  );

  lkp_lane_map u_map (
    .data_i(tx_word), .fr_i(tx_fr), .md_i(tx_md), .pb_i(tx_pb),
    .lanes_o(tx_lanes)
  );

  lkp_rx_check #(.VAL_W(VAL_W), .NRM_W(NRM_W)) u_rx (
    .clk(clk), .rst_n(rst_n_i), .lanes_i(rx_lanes),
    .word_o(rx_word), .par_err_o(rx_par_err), .sync_err_o(rx_sync_err)
  );
endmodule

// File: tb/sim_tt_link_framer.sv
module sim_tt_link_framer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [319:0] tx_pay;
  logic         tx_mon;
  logic [41:0]  tx_lanes, rx_lanes;
  logic [31:0]  rx_word;
  logic         rx_par_err, rx_sync_err;
  logic [41:0]  mask = '0;

  int total = 0;
  int fails = 0;

  logic [319:0] nxt_pay, pend_pay, cur_pay;
  logic         nxt_mon, pend_mon, cur_mon;
  int           m_k = 0;
  bit           m_started = 0;
  int           frames_seen = 0;
  logic [41:0]  last_lanes = '0;

  always #4 clk = ~clk;

  assign rx_lanes = tx_lanes ^ mask;

  tt_link_framer u0 (
    .clk(clk), .rst_n(rst_n), .tx_pay(tx_pay), .tx_mon(tx_mon),
    .tx_lanes(tx_lanes), .rx_lanes(rx_lanes), .rx_word(rx_word),
    .rx_par_err(rx_par_err), .rx_sync_err(rx_sync_err)
  );

  function automatic logic [319:0] mkpay(input int s, input bit hi);
    logic [319:0] p;
    if (s < 0) return '1;
    if (s == 0) return '0;
    for (int t = 0; t < 32; t++) begin
      p[10*t +: 10] = 10'((s * 97 + t * 53 + t * t * 7) & 10'h3FF);
      if (hi) p[10*t + 8] = 1'b1;
      if (hi) p[10*t + 9] = 1'b1;
    end
    return p;
  endfunction

  function automatic logic [31:0] plane(input logic [319:0] p, input int k);
    logic [31:0] d;
    for (int t = 0; t < 32; t++) d[t] = p[10*t + k];
    return d;
  endfunction

  function automatic logic [41:0] mk_lanes(input logic [31:0] d, input logic fr,
                                           input logic md, input logic pb);
    logic [41:0] l;
    l[6:0]   = {fr, d[5:0]};
    l[13:7]  = {md, d[13:8]};
    l[20:14] = {pb, d[21:16]};
    l[27:21] = {1'b0, d[23], d[22], d[15], d[14], d[7], d[6]};
    l[34:28] = {1'b0, d[29:24]};
    l[41:35] = {5'b0, d[31:30]};
    return l;
  endfunction

  function automatic logic [31:0] unlane(input logic [41:0] l);
    logic [31:0] d;
    d[5:0]   = l[5:0];
    d[13:8]  = l[12:7];
    d[21:16] = l[19:14];
    d[6]     = l[21];
    d[7]     = l[22];
    d[14]    = l[23];
    d[15]    = l[24];
    d[22]    = l[25];
    d[23]    = l[26];
    d[29:24] = l[33:28];
    d[31:30] = l[36:35];
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One link word: checks receiver result for the previous word, then the new tx word.
  task automatic step(input bit ep, input bit es, input string tag);
    logic [31:0] rx_exp;
    logic [31:0] d;
    logic [41:0] ex;
    int          len;
    rx_exp = unlane(last_lanes ^ mask);
    @(negedge clk);
    mask = '0;
    chk(rx_word === rx_exp, "R8 rx_word", 64'(rx_word), 64'(rx_exp));
    chk(rx_par_err === ep, {"R9 parity flag ", tag}, 64'(rx_par_err), 64'(ep));
    chk(rx_sync_err === es, {"R10 sync flag ", tag}, 64'(rx_sync_err), 64'(es));
    if (!m_started) begin
      if (tx_lanes[6] !== 1'b1) begin
        chk(tx_lanes === '0, "R1 idle lanes before first crossing", 64'(tx_lanes), 64'd0);
        last_lanes = '0;
        return;
      end
      m_started = 1;
      m_k = -1;
    end
    len = cur_mon ? 10 : 8;
    m_k++;
    if (m_k >= len) m_k = 0;
    if (m_k == 0) begin
      cur_pay = pend_pay;
      cur_mon = pend_mon;
      pend_pay = nxt_pay;
      pend_mon = nxt_mon;
      tx_pay = pend_pay;
      tx_mon = pend_mon;
      frames_seen++;
    end
    if (m_k == 2) begin
      tx_pay = ~pend_pay;
      tx_mon = ~pend_mon;
    end
    if (m_k == 4) begin
      tx_pay = pend_pay;
      tx_mon = pend_mon;
    end
    d  = plane(cur_pay, m_k);
    ex = mk_lanes(d, m_k == 0, cur_mon, ^d);
    chk(tx_lanes[6] === (m_k == 0), "R2 framing position", 64'(tx_lanes[6]), 64'(m_k == 0));
    chk(unlane(tx_lanes) === d, cur_mon ? "R3 R7 bit plane" : "R3 R4 R7 bit plane",
        64'(unlane(tx_lanes)), 64'(d));
    chk(tx_lanes === ex, "R5 lane routing", 64'(tx_lanes), 64'(ex));
    chk(^{unlane(tx_lanes), tx_lanes[20]} === 1'b0, "R6 even parity",
        64'(tx_lanes[20]), 64'(^d));
    last_lanes = ex;
  endtask

  task automatic run_frames(input int n, input bit mon, input int seed, input bit hi);
    for (int f = 0; f < n; f++) begin
      int target;
      nxt_pay = mkpay(seed + f, hi);
      nxt_mon = mon;
      target = frames_seen + 1;
      while (frames_seen < target) step(0, 0, "clean");
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_lanes === '0, "R1 reset lanes", 64'(tx_lanes), 64'd0);
    chk(rx_word === '0, "R1 reset rx_word", 64'(rx_word), 64'd0);
    chk(rx_par_err === 1'b0, "R1 reset parity flag", 64'(rx_par_err), 64'd0);
    chk(rx_sync_err === 1'b0, "R1 reset sync flag", 64'(rx_sync_err), 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_parity;
    while (m_k != 3) step(0, 0, "R9 pre");
    mask = 42'd1 << 9;
    step(1, 0, "R9 flipped data bit");
    step(0, 0, "R9 after fault");
  endtask

  task automatic t_early_frame;
    while (m_k != 3) step(0, 0, "R10 pre");
    mask = 42'd1 << 6;
    step(0, 1, "R10 early framing");
    while (m_k != 0) step(0, 0, "R10 resync count");
    step(0, 1, "R10 framing at wrong count");
    run_frames(2, 0, 50, 0);
  endtask

  task automatic t_missing_frame;
    while (m_k != 0) step(0, 0, "R11 pre");
    mask = 42'd1 << 6;
    step(0, 1, "R10 missing framing");
    while (m_k != 0) step(0, 0, "R11 unlocked quiet");
    step(0, 0, "R11 relock without fault");
    run_frames(2, 1, 60, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
    $finish;
  end

  initial begin
    pend_pay = mkpay(1, 0);
    pend_mon = 1'b0;
    cur_pay  = '0;
    cur_mon  = 1'b0;
    nxt_pay  = mkpay(2, 0);
    nxt_mon  = 1'b0;
    tx_pay   = pend_pay;
    tx_mon   = pend_mon;
    t_reset();
    run_frames(3, 0, 10, 0);
    run_frames(3, 1, 20, 0);
    run_frames(2, 0, 30, 1);
    run_frames(1, 1, -1, 0);
    run_frames(1, 0, 0, 0);
    run_frames(2, 0, 35, 0);
    t_parity();
    t_early_frame();
    t_missing_frame();
    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
    $finish;
  end
endmodule